// File: doc/BRIEF.md
# Pointer Masking Address Transform

This block prepares a 64-bit data or instruction address for the memory pipeline when pointer masking is in use. It first settles which privilege level and which virtualization state govern the access. A non-fetch access may borrow a saved privilege when modify-privilege is on, or a guest privilege when it is a forced-virtual access. From that effective context it picks one of five 2-bit masking configuration fields and turns the chosen code into a mask length of 0, 7 or 16 bits. The top bits of the address are then replaced. An access that bypasses translation gets zeros in those bits. A translated access gets copies of the highest kept bit.

The transform is pure combinational logic. The parameter `OUT_REG` adds one register stage at the outputs: with the default of 1, results appear one clock after their inputs, and with 0 the outputs follow the inputs directly. A privilege encoding that no configuration case covers is reported on `illegalSel`, and in that case no masking is applied.

Top module: `ptr_mask_xform`

## Requirements
- R1: When `accType` is 0 (fetch), `effPriv` equals `curPriv` and `effVirt` equals `curVirt`, whatever the override inputs say. Privilege codes: 0 user, 1 supervisor, 2 reserved, 3 machine.
- R2: For a non-fetch access (`accType` 1 or 2, and 3 behaves the same) with `modPrivEn` high and `forcedVirt` low, `effPriv` equals `prevPriv`. `effVirt` is `curVirt` OR (`prevVirt` AND `prevPriv` is not 3).
- R3: For a non-fetch access with `forcedVirt` high, `effVirt` is 1 and `effPriv` is {0, `guestPrivSup`}. This takes precedence over R2.
- R4: `maskLen` is 0 whenever `is64` is low, when `execReadAcc` is high, or when `modPrivEn` and `execReadable` are both high.
- R5: The configuration field is chosen by the first of these cases that matches:
  - effective machine: `machMaskCfg`;
  - non-virtual supervisor, or user with `sExtPresent` low and non-virtual: `envMaskCfg`;
  - virtual supervisor: `hypMaskCfg`;
  - `curPriv` user with `forcedVirt` high: `guestUserMaskCfg`;
  - any remaining effective user case: `supMaskCfg`.
- R6: A selected field value of 2 gives `maskLen` = 7, a value of 3 gives 16, and 0 or 1 give 0.
- R7: An access is physical when `effPriv` is 3 or when the translation-off flag of its context is high. That flag is `guestXlateOff` if `effVirt` is high and `hostXlateOff` otherwise. For a physical access, `xformAddr` keeps the low (64 − `maskLen`) bits of `addrIn` and zeroes the rest.
- R8: For a non-physical access, `xformAddr` sign-extends `addrIn` from bit (63 − `maskLen`). With `maskLen` 0 the address passes unchanged.
- R9: An effective privilege of 2 matches no case of R5. It drives `illegalSel` high and forces `maskLen` to 0.
- R10: With `OUT_REG` = 1, every output shows the result for the inputs present one rising clock edge earlier, and all outputs are 0 while `rstN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low synchronous reset of the output stage |
| addrIn | input | 64 | Address before masking |
| accType | input | 2 | 0 fetch, 1 load, 2 store |
| curPriv | input | 2 | Current privilege level |
| curVirt | input | 1 | Current virtualization state |
| is64 | input | 1 | Hart is running with 64-bit registers |
| modPrivEn | input | 1 | Modify-privilege is active for data accesses |
| prevPriv | input | 2 | Saved privilege used under modify-privilege |
| prevVirt | input | 1 | Saved virtualization state used under modify-privilege |
| execReadable | input | 1 | Execute-only pages readable flag |
| guestPrivSup | input | 1 | Guest access privilege for forced-virtual accesses (1 supervisor) |
| forcedVirt | input | 1 | Access is a forced-virtual (guest) access |
| execReadAcc | input | 1 | Access reads execute-permission memory |
| sExtPresent | input | 1 | Supervisor mode is implemented |
| machMaskCfg | input | 2 | Masking code for machine level |
| envMaskCfg | input | 2 | Masking code set by machine for the level below |
| hypMaskCfg | input | 2 | Masking code for virtual supervisor |
| guestUserMaskCfg | input | 2 | Masking code for virtual user under forced-virtual access |
| supMaskCfg | input | 2 | Masking code for user level set by supervisor |
| hostXlateOff | input | 1 | Translation off for the non-virtual context |
| guestXlateOff | input | 1 | Translation off for the virtual context |
| xformAddr | output | 64 | Transformed address |
| effPriv | output | 2 | Effective privilege |
| effVirt | output | 1 | Effective virtualization state |
| maskLen | output | 5 | Number of masked top bits |
| illegalSel | output | 1 | No configuration case matched |

## Verification
The privilege override and the fill choice interact in the same cycle. A modify-privilege or forced-virtual load changes the effective context, and that one change picks both the configuration field that sets the mask length and the translation-off flag that chooses between zero fill and sign fill. Directed vectors make the override alone flip the result, for example a saved machine privilege that turns a sign-extended user address into a zero-filled one. Random vectors cover all combinations of privilege, virtualization and override, with random addresses. Every output is compared one cycle later with a bench model written directly from the requirements.

// File: rtl/ptr_mask_pkg.sv
package ptr_mask_pkg;

  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_RSVD  = 2'd2;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  localparam logic [1:0] ACC_FETCH  = 2'd0;

  localparam logic [1:0] CFG_SHORT  = 2'd2;
  localparam logic [1:0] CFG_LONG   = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic zeroFill;   // physical access: fill with zeros
    logic useShort;   // apply the short mask
    logic useLong;    // apply the long mask
  } maskStrobe_t;

endpackage

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import ptr_mask_pkg::*;
(
  input  logic [1:0]  accType,
  input  logic [1:0]  curPriv,
  input  logic        curVirt,
  input  logic        is64,
  input  logic        modPrivEn,
  input  logic [1:0]  prevPriv,
  input  logic        prevVirt,
  input  logic        execReadable,
  input  logic        guestPrivSup,
  input  logic        forcedVirt,
  input  logic        execReadAcc,
  input  logic        sExtPresent,
  input  logic [1:0]  machMaskCfg,
  input  logic [1:0]  envMaskCfg,
  input  logic [1:0]  hypMaskCfg,
  input  logic [1:0]  guestUserMaskCfg,
  input  logic [1:0]  supMaskCfg,
  input  logic        hostXlateOff,
  input  logic        guestXlateOff,
  output logic [1:0]  effPriv,
  output logic        effVirt,
  output logic        illegalSel,
  output maskStrobe_t strobes
);

  logic [1:0] cfgSel;
  logic       maskOff;
  logic       xlateOff;

  // effective context: saved privilege first, forced-virtual overrides it
  always_comb begin
    effPriv = curPriv;
    effVirt = curVirt;
    if (accType != ACC_FETCH) begin
      if (modPrivEn) begin
        effPriv = prevPriv;
        if (prevVirt && (prevPriv != PRIV_MACH)) effVirt = 1'b1;
      end
      if (forcedVirt) begin
        effVirt = 1'b1;
        effPriv = {1'b0, guestPrivSup};
      end
    end
  end

  // configuration field selection, in priority order
  always_comb begin
    cfgSel     = 2'd0;
    illegalSel = 1'b0;
    if (effPriv == PRIV_MACH)
      cfgSel = machMaskCfg;
    else if (!effVirt && ((effPriv == PRIV_SUPER) ||
                          (!sExtPresent && (effPriv == PRIV_USER))))
      cfgSel = envMaskCfg;
    else if (effVirt && (effPriv == PRIV_SUPER))
      cfgSel = hypMaskCfg;
    else if ((curPriv == PRIV_USER) && forcedVirt)
      cfgSel = guestUserMaskCfg;
    else if (effPriv == PRIV_USER)
      cfgSel = supMaskCfg;
    else
      illegalSel = 1'b1;
  end

  assign maskOff  = !is64 || execReadAcc || (modPrivEn && execReadable) || illegalSel;
  assign xlateOff = effVirt ? guestXlateOff : hostXlateOff;

  always_comb begin
    strobes.zeroFill = (effPriv == PRIV_MACH) || xlateOff;
    strobes.useShort = !maskOff && (cfgSel == CFG_SHORT);
    strobes.useLong  = !maskOff && (cfgSel == CFG_LONG);
  end

endmodule

// File: rtl/pmx_datapath.sv
module pmx_datapath
  import ptr_mask_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int MASK_SHORT = 7,
  parameter int MASK_LONG  = 16
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  maskStrobe_t       strobes,
  output logic [ADDR_W-1:0] xformAddr
);

  localparam int SHORT_TOP = ADDR_W - 1 - MASK_SHORT;  // highest kept bit, short mask
  localparam int LONG_TOP  = ADDR_W - 1 - MASK_LONG;   // highest kept bit, long mask

  logic shortFill;
  logic longFill;

  assign shortFill = strobes.zeroFill ? 1'b0 : addrIn[SHORT_TOP];
  assign longFill  = strobes.zeroFill ? 1'b0 : addrIn[LONG_TOP];

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i > SHORT_TOP) begin : g_inShort
      // covered by both masks
      assign xformAddr[i] = strobes.useLong  ? longFill  :
                            strobes.useShort ? shortFill : addrIn[i];
    end else if (i > LONG_TOP) begin : g_inLong
      assign xformAddr[i] = strobes.useLong ? longFill : addrIn[i];
    end else begin : g_kept
      assign xformAddr[i] = addrIn[i];
    end
  end

endmodule

// File: rtl/ptr_mask_xform.sv
module ptr_mask_xform
  import ptr_mask_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int MASK_SHORT = 7,
  parameter int MASK_LONG  = 16,
  parameter bit OUT_REG    = 1'b1,
  parameter int LEN_W      = $clog2(MASK_LONG + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        accType,
  input  logic [1:0]        curPriv,
  input  logic              curVirt,
  input  logic              is64,
  input  logic              modPrivEn,
  input  logic [1:0]        prevPriv,
  input  logic              prevVirt,
  input  logic              execReadable,
  input  logic              guestPrivSup,
  input  logic              forcedVirt,
  input  logic              execReadAcc,
  input  logic              sExtPresent,
  input  logic [1:0]        machMaskCfg,
  input  logic [1:0]        envMaskCfg,
  input  logic [1:0]        hypMaskCfg,
  input  logic [1:0]        guestUserMaskCfg,
  input  logic [1:0]        supMaskCfg,
  input  logic              hostXlateOff,
  input  logic              guestXlateOff,
  output logic [ADDR_W-1:0] xformAddr,
  output logic [1:0]        effPriv,
  output logic              effVirt,
  output logic [LEN_W-1:0]  maskLen,
  output logic              illegalSel
);

  maskStrobe_t       strobes;
  logic [1:0]        effPrivC;
  logic              effVirtC;
  logic              illegalC;
  logic [LEN_W-1:0]  maskLenC;
  logic [ADDR_W-1:0] xformC;

  pmx_ctrl u_ctrl (
    .accType(accType), .curPriv(curPriv), .curVirt(curVirt), .is64(is64),
    .modPrivEn(modPrivEn), .prevPriv(prevPriv), .prevVirt(prevVirt),
    .execReadable(execReadable), .guestPrivSup(guestPrivSup),
    .forcedVirt(forcedVirt), .execReadAcc(execReadAcc), .sExtPresent(sExtPresent),
    .machMaskCfg(machMaskCfg), .envMaskCfg(envMaskCfg), .hypMaskCfg(hypMaskCfg),
    .guestUserMaskCfg(guestUserMaskCfg), .supMaskCfg(supMaskCfg),
    .hostXlateOff(hostXlateOff), .guestXlateOff(guestXlateOff),
    .effPriv(effPrivC), .effVirt(effVirtC), .illegalSel(illegalC), .strobes(strobes)
  );

  pmx_datapath #(
    .ADDR_W(ADDR_W), .MASK_SHORT(MASK_SHORT), .MASK_LONG(MASK_LONG)
  ) u_data (
    .addrIn(addrIn), .strobes(strobes), .xformAddr(xformC)
  );

  assign maskLenC = strobes.useLong  ? LEN_W'(MASK_LONG)  :
                    strobes.useShort ? LEN_W'(MASK_SHORT) : '0;

  if (OUT_REG) begin : g_outReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        xformAddr  <= '0;
        effPriv    <= '0;
        effVirt    <= 1'b0;
        maskLen    <= '0;
        illegalSel <= 1'b0;
      end else begin
        xformAddr  <= xformC;
        effPriv    <= effPrivC;
        effVirt    <= effVirtC;
        maskLen    <= maskLenC;
        illegalSel <= illegalC;
      end
    end

    assert_stage_delay_R10: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (xformAddr == $past(xformC) && maskLen == $past(maskLenC)));
  end else begin : g_noReg
    assign xformAddr  = xformC;
    assign effPriv    = effPrivC;
    assign effVirt    = effVirtC;
    assign maskLen    = maskLenC;
    assign illegalSel = illegalC;
  end

  assert_fetch_keeps_ctx_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accType == ACC_FETCH) |-> (effPrivC == curPriv && effVirtC == curVirt));

  assert_forced_virt_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accType != ACC_FETCH && forcedVirt) |-> (effVirtC && effPrivC == {1'b0, guestPrivSup}));

  assert_mask_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!is64 || execReadAcc || (modPrivEn && execReadable)) |-> (maskLenC == '0));

  assert_mach_long_R6: assert property (@(posedge clk) disable iff (!rstN)
    (is64 && !execReadAcc && !(modPrivEn && execReadable) &&
     effPrivC == PRIV_MACH && machMaskCfg == CFG_LONG) |-> (maskLenC == LEN_W'(MASK_LONG)));

  assert_mach_zero_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (effPrivC == PRIV_MACH && maskLenC != '0) |-> (xformC[ADDR_W-1] == 1'b0));

  assert_sign_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (effPrivC == PRIV_USER && !effVirtC && !hostXlateOff && maskLenC == LEN_W'(MASK_LONG))
      |-> (xformC[ADDR_W-1] == addrIn[ADDR_W-1-MASK_LONG]));

  assert_illegal_nomask_R9: assert property (@(posedge clk) disable iff (!rstN)
    illegalC |-> (maskLenC == '0 && effPrivC == PRIV_RSVD && xformC == addrIn));

endmodule

// File: tb/ptr_mask_xform_tb.sv
`timescale 1ns/1ps
module ptr_mask_xform_tb;

  typedef struct packed {
    logic [63:0] addr;
    logic [1:0]  acc, cur, prev;
    logic        virt, is64, modPriv, prevV, exeRd, gSup, forced, exeAcc, sExt;
    logic [1:0]  cM, cE, cH, cG, cS;
    logic        hOff, gOff;
  } stim_t;

  typedef struct packed {
    logic [63:0] addr;
    logic [1:0]  priv;
    logic        virt;
    logic [4:0]  len;
    logic        ill;
  } resp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  stim_t s;
  logic [63:0] xformAddr;
  logic [1:0]  effPriv;
  logic        effVirt;
  logic [4:0]  maskLen;
  logic        illegalSel;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptr_mask_xform u_dut (
    .clk(clk), .rstN(rstN), .addrIn(s.addr), .accType(s.acc), .curPriv(s.cur),
    .curVirt(s.virt), .is64(s.is64), .modPrivEn(s.modPriv), .prevPriv(s.prev),
    .prevVirt(s.prevV), .execReadable(s.exeRd), .guestPrivSup(s.gSup),
    .forcedVirt(s.forced), .execReadAcc(s.exeAcc), .sExtPresent(s.sExt),
    .machMaskCfg(s.cM), .envMaskCfg(s.cE), .hypMaskCfg(s.cH),
    .guestUserMaskCfg(s.cG), .supMaskCfg(s.cS), .hostXlateOff(s.hOff),
    .guestXlateOff(s.gOff), .xformAddr(xformAddr), .effPriv(effPriv),
    .effVirt(effVirt), .maskLen(maskLen), .illegalSel(illegalSel)
  );

  function automatic resp_t model(stim_t t);
    resp_t r;
    logic [1:0] code;
    logic found, gate, phys, offFlag;
    r.priv = t.cur;
    r.virt = t.virt;
    if (t.acc != 2'd0 && t.forced) begin          // R3
      r.virt = 1'b1;
      r.priv = {1'b0, t.gSup};
    end else if (t.acc != 2'd0 && t.modPriv) begin // R2
      r.priv = t.prev;
      r.virt = t.virt | (t.prevV && t.prev != 2'd3);
    end
    found = 1'b1;
    code = 2'd0;
    if (r.priv == 2'd3) code = t.cM;
    else if (!r.virt && r.priv == 2'd1) code = t.cE;
    else if (!r.virt && r.priv == 2'd0 && !t.sExt) code = t.cE;
    else if (r.virt && r.priv == 2'd1) code = t.cH;
    else if (t.cur == 2'd0 && t.forced) code = t.cG;
    else if (r.priv == 2'd0) code = t.cS;
    else found = 1'b0;
    r.ill = !found;
    gate = !t.is64 || t.exeAcc || (t.modPriv && t.exeRd) || r.ill;
    r.len = gate ? 5'd0 : (code == 2'd3) ? 5'd16 : (code == 2'd2) ? 5'd7 : 5'd0;
    offFlag = r.virt ? t.gOff : t.hOff;
    phys = (r.priv == 2'd3) || offFlag;
    if (phys) r.addr = (t.addr << r.len) >> r.len;
    else      r.addr = 64'($signed(t.addr << r.len) >>> r.len);
    return r;
  endfunction

  function automatic stim_t base();
    stim_t t = '0;
    t.is64 = 1'b1;
    t.sExt = 1'b1;
    t.acc  = 2'd1;
    t.addr = 64'h8123_4567_89AB_CDEF;
    return t;
  endfunction

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // apply a vector, wait for the register stage, compare everything
  task automatic run(stim_t t, string req);
    resp_t e;
    @(negedge clk);
    s = t;
    e = model(t);
    @(posedge clk);
    @(negedge clk);
    cmp(req, "addr", xformAddr, e.addr);
    cmp(req, "priv", 64'(effPriv), 64'(e.priv));
    cmp(req, "virt", 64'(effVirt), 64'(e.virt));
    cmp(req, "len",  64'(maskLen), 64'(e.len));
    cmp(req, "ill",  64'(illegalSel), 64'(e.ill));
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    stim_t t;
    int unused;
    unused = $urandom(32'd20240611);
    s = base();
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R10", "reset addr", xformAddr, 64'd0);
    cmp("R10", "reset len", 64'(maskLen), 64'd0);
    rstN = 1'b1;

    // R1 fetch ignores overrides
    t = base(); t.acc = 2'd0; t.cur = 2'd0; t.modPriv = 1'b1; t.prev = 2'd3;
    t.forced = 1'b1; t.cS = 2'd3; run(t, "R1");
    // R2 saved machine privilege: no virt, zero fill
    t = base(); t.cur = 2'd0; t.modPriv = 1'b1; t.prev = 2'd3; t.prevV = 1'b1;
    t.cM = 2'd3; run(t, "R2");
    // R2 saved supervisor with virt -> virtual supervisor
    t = base(); t.modPriv = 1'b1; t.prev = 2'd1; t.prevV = 1'b1; t.cH = 2'd2;
    run(t, "R2");
    // R3 forced virtual beats modify-privilege, guest user field
    t = base(); t.acc = 2'd2; t.cur = 2'd0; t.modPriv = 1'b1; t.prev = 2'd3;
    t.forced = 1'b1; t.gSup = 1'b0; t.cG = 2'd3; run(t, "R3");
    // R4 gates
    t = base(); t.cur = 2'd3; t.cM = 2'd3; t.is64 = 1'b0; run(t, "R4");
    t = base(); t.cur = 2'd3; t.cM = 2'd3; t.exeAcc = 1'b1; run(t, "R4");
    t = base(); t.cur = 2'd1; t.cE = 2'd3; t.modPriv = 1'b1; t.prev = 2'd1;
    t.exeRd = 1'b1; run(t, "R4");
    // R5 user without supervisor mode uses machine env field
    t = base(); t.cur = 2'd0; t.sExt = 1'b0; t.cE = 2'd2; t.cS = 2'd3; run(t, "R5");
    t = base(); t.cur = 2'd0; t.cS = 2'd2; t.cE = 2'd3; run(t, "R5");
    // R6 codes 0 and 1 give no mask
    t = base(); t.cur = 2'd3; t.cM = 2'd1; run(t, "R6");
    // R7 host translation off, supervisor, zero fill of negative address
    t = base(); t.cur = 2'd1; t.cE = 2'd3; t.hOff = 1'b1; run(t, "R7");
    // R8 virtual user, guest translation on while host off: sign fill
    t = base(); t.cur = 2'd0; t.virt = 1'b1; t.hOff = 1'b1; t.cS = 2'd3;
    t.addr = 64'h0000_8000_0000_1234; run(t, "R8");
    // R9 reserved effective privilege
    t = base(); t.modPriv = 1'b1; t.prev = 2'd2; t.cM = 2'd3; t.cS = 2'd3; run(t, "R9");

    // R10 output holds until the edge
    t = base(); t.cur = 2'd3; t.cM = 2'd3; run(t, "R10");
    @(negedge clk);
    s.cM = 2'd0;
    #1;
    cmp("R10", "hold len", 64'(maskLen), 64'd16);

    for (int i = 0; i < 4000; i++) begin
      t = stim_t'({$urandom, $urandom, $urandom, $urandom});
      if (($urandom % 4) != 0) t.is64 = 1'b1;
      if (($urandom % 3) != 0) t.exeAcc = 1'b0;
      run(t, "R8");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule